// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves 8-bit frames in both directions at once over a clocked serial link. A host writes a byte into a transmit holding register. When the start conditions hold, the byte moves into a shift register and is sent on `txd`. At the same time, bits arriving on `rxd` are collected and, once the frame is complete, placed in a receive holding register for the host to read. The whole block runs on the system clock `clk`.

The transfer clock has two possible sources. It can come from an internal divider, in which case the block drives `sclk_out` with the output enable `sclk_oe` high. It can also come from outside on `sclk_in`, after a two-stage synchroniser.

Configuration inputs select the following:
- clock polarity;
- bit order;
- line inversion;
- flow control: none, clear-to-send gating, or a request-to-send output;
- the event that raises the transmit interrupt;
- a continuous-receive mode in which reading the receive register starts the next frame.

If a new frame reaches its seventh bit while the previous byte is still unread, the receiver raises an overrun.

Top module: `csio_channel`

## Requirements
- R1: A frame is 8 bits. On the 8th sampling edge, the assembled byte is written to `rx_data` when `cfg_rx_en`=1, `rx_full` is set, and `rx_irq` is high for exactly one clock.
- R2: With `cfg_ext_clk`=0, `sclk_oe`=1 and the transfer clock period is 2*(`cfg_div`+1) clocks.
- R3: With `cfg_pol`=0, the transfer clock idles high, `txd` changes on falling edges and `rxd` is sampled on rising edges. With `cfg_pol`=1, the idle level is low and both edges are swapped. The first bit is on `txd` before the first edge.
- R4: With `cfg_msb_first`=0, bit 0 is transferred first; with 1, bit 7 is first. The same order applies to transmit and receive.
- R5: A write sets `tx_empty`=0. A frame starts only when all of the following hold: `cfg_tx_en`=1, `tx_empty`=0 (or a continuous-receive re-arm is pending), and, when `cfg_flow`=01, the synchronised `cts_n` is 0. The start sets `tx_empty`=1.
- R6: If `rx_full`=1 when the 7th bit of a new frame is sampled:
  - `overrun` is set and stays set until a read;
  - that frame is discarded, so `rx_data` keeps the earlier byte;
  - `rx_irq` does not pulse for that frame.
- R7: With `cfg_tx_irq_sel`=0, `tx_irq` pulses one clock after the buffer-to-shifter move. With 1, it pulses in the same cycle as the end of the frame.
- R8: With `cfg_cont_rx`=1 and `cfg_rx_en`=1, a read of the receive register starts another frame from the retained transmit byte, without a write, and `tx_empty` stays 1. With `cfg_cont_rx`=0, a read starts nothing.
- R9: With `cfg_invert`=1, both transmitted and received bits are inverted on the pins.
- R10: With `cfg_flow`=10, `rts_n` = 0 exactly when `cfg_rx_en`=1 and `rx_full`=0. With any other `cfg_flow` value, `rts_n` = 0.
- R11: With `cfg_ext_clk`=1, `sclk_oe`=0, no frame advances without edges on `sclk_in`, and frames move on the synchronised external edges. Each external half period must be at least 4 clocks.
- R12: A pulse on `rd_rx` clears `rx_full` and `overrun`, unless a frame completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_tx | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | DATA_W | Byte to transmit |
| rd_rx | input | 1 | Read strobe for the receive holding register |
| rx_data | output | DATA_W | Receive holding register |
| cfg_tx_en | input | 1 | Transmit enable |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_ext_clk | input | 1 | 1: transfer clock from `sclk_in` |
| cfg_pol | input | 1 | Clock polarity |
| cfg_msb_first | input | 1 | Bit order |
| cfg_invert | input | 1 | Data line inversion |
| cfg_flow | input | 2 | 00/11 none, 01 clear-to-send, 10 request-to-send |
| cfg_tx_irq_sel | input | 1 | 0: buffer move, 1: frame end |
| cfg_cont_rx | input | 1 | Continuous-receive mode |
| cfg_div | input | DIV_W | Divider setting n |
| tx_empty | output | 1 | Transmit holding register empty |
| rx_full | output | 1 | Receive holding register holds unread data |
| overrun | output | 1 | Overrun flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | External transfer clock |
| sclk_out | output | 1 | Internal transfer clock |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| txd | output | 1 | Serial data out |
| rxd | input | 1 | Serial data in |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The bench builds the block with its default parameters: 8-bit frames, an 8-bit divider and two synchroniser stages. It loops `txd` back to `rxd`, so every transmitted byte must also come back in `rx_data`. Changing `cfg_div` at run time to 0, 1 and 3 brings the divider arithmetic and the minimum half period within reach without long runs. The two-stage synchroniser sets the external clock half period the bench uses, 5 clocks, which is just above the minimum.

// File: rtl/csio_pkg.sv
// Shared types of the clock-synchronous serial channel.
package csio_pkg;
    // Flow-control selection; the two-bit code is decoded by the top module.
    typedef enum logic [1:0] {
        FLOW_NONE  = 2'b00,
        FLOW_CTS   = 2'b01,
        FLOW_RTS   = 2'b10,
        FLOW_NONE2 = 2'b11
    } flow_e;
endpackage

// File: rtl/csio_sync.sv
// Multi-stage synchroniser for asynchronous pin inputs.
// Assumes inputs are level signals; each bit is synchronised independently.
module csio_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // Shift the pin values through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/csio_clkgen.sv
// Transfer-clock phase generator.
// The phase is 0 at idle. A rising phase is a launch edge and a falling phase
// is a sample edge. Internally, the phase toggles every div+1 clocks while run
// is high. Externally, edges of the already synchronised ext_phase are used.
module csio_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_mode,
    input  logic [DIV_W-1:0] div,
    input  logic             ext_phase,
    output logic             phase,
    output logic             launch,
    output logic             sample
);
    logic [DIV_W-1:0] cnt;
    logic             ph_int;
    logic             ext_prev;
    logic             tick;

    assign tick  = run && !ext_mode && (cnt == div);
    assign phase = ph_int;

    // Count the half period and toggle the internal phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            ph_int <= 1'b0;
        end else if (!run || ext_mode) begin
            cnt    <= '0;
            ph_int <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            ph_int <= ~ph_int;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // Remember the previous external phase for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_phase;
    end

    // Select the edge events from the active clock source.
    always_comb begin
        if (ext_mode) begin
            launch = run &&  ext_phase && !ext_prev;
            sample = run && !ext_phase &&  ext_prev;
        end else begin
            launch = tick && !ph_int;
            sample = tick &&  ph_int;
        end
    end
endmodule

// File: rtl/csio_shift.sv
// Transmit and receive shift registers with a shared bit counter.
// Assumes launch and sample only occur while a frame is running and alternate.
// The first bit is presented at load time; later bits move on launch edges.
module csio_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         msb_first,
    input  logic         launch,
    input  logic         sample,
    input  logic         rx_bit,
    output logic         tx_bit,
    output logic [W-1:0] rx_next,
    output logic         done,
    output logic         seventh
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  tx_sh;
    logic [W-1:0]  rx_sh;
    logic [W-1:0]  load_rev;
    logic [CW-1:0] cnt;

    // Mirror the load byte so the transmitter always shifts toward bit 0.
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign load_rev[i] = load_data[W-1-i];
    end

    assign tx_bit  = tx_sh[0];
    assign rx_next = msb_first ? {rx_sh[W-2:0], rx_bit} : {rx_bit, rx_sh[W-1:1]};
    assign done    = sample && (cnt == CW'(W - 1));
    assign seventh = sample && (cnt == CW'(W - 2));

    // Load, shift out on launch edges after the first, shift in on sample edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '1;
            rx_sh <= '0;
            cnt   <= '0;
        end else if (load) begin
            tx_sh <= msb_first ? load_rev : load_data;
            cnt   <= '0;
        end else begin
            if (sample) begin
                rx_sh <= rx_next;
                cnt   <= done ? '0 : cnt + 1'b1;
            end
            if (launch && cnt != '0) tx_sh <= {1'b1, tx_sh[W-1:1]};
        end
    end
endmodule

// File: rtl/csio_channel.sv
// Full-duplex clock-synchronous serial channel with holding registers,
// flow control, overrun detection and continuous-receive re-arm.
// Assumes a synchronous active-low reset, that configuration changes only
// between frames, and that external clock half periods are at least
// SYNC_STAGES+2 clocks long.
module csio_channel
    import csio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_tx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_rx,
    output logic [DATA_W-1:0] rx_data,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_ext_clk,
    input  logic              cfg_pol,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic [1:0]        cfg_flow,
    input  logic              cfg_tx_irq_sel,
    input  logic              cfg_cont_rx,
    input  logic [DIV_W-1:0]  cfg_div,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              tx_irq,
    output logic              rx_irq,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              txd,
    input  logic              rxd,
    input  logic              cts_n,
    output logic              rts_n
);
    flow_e             flow;
    logic              sclk_s, cts_s;
    logic              busy, start, from_buf, cts_ok, rearm, frame_ovr;
    logic [DATA_W-1:0] tb, rb;
    logic              phase, launch, sample, ext_phase;
    logic              tx_bit, done, seventh;
    logic [DATA_W-1:0] rx_next;

    assign flow      = flow_e'(cfg_flow);
    assign cts_ok    = (flow != FLOW_CTS) || !cts_s;
    assign from_buf  = !tx_empty;
    assign start     = !busy && cfg_tx_en && cts_ok && (from_buf || rearm);
    assign ext_phase = sclk_s ^ ~cfg_pol;

    csio_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, cts_n}),
        .q     ({sclk_s, cts_s})
    );

    csio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .ext_mode  (cfg_ext_clk),
        .div       (cfg_div),
        .ext_phase (ext_phase),
        .phase     (phase),
        .launch    (launch),
        .sample    (sample)
    );

    csio_shift #(.W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_data (tb),
        .msb_first (cfg_msb_first),
        .launch    (launch),
        .sample    (sample),
        .rx_bit    (rxd ^ cfg_invert),
        .tx_bit    (tx_bit),
        .rx_next   (rx_next),
        .done      (done),
        .seventh   (seventh)
    );

    assign txd      = tx_bit ^ cfg_invert;
    assign sclk_out = phase ^ ~cfg_pol;
    assign sclk_oe  = ~cfg_ext_clk;
    assign rts_n    = (flow == FLOW_RTS) ? ~(cfg_rx_en & ~rx_full) : 1'b0;
    assign rx_data  = rb;

    // Track whether a frame is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (done)  busy <= 1'b0;
    end

    // Transmit holding register and its empty flag; a write wins over a move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tb       <= '0;
            tx_empty <= 1'b1;
        end else if (wr_tx) begin
            tb       <= wr_data;
            tx_empty <= 1'b0;
        end else if (start && from_buf) begin
            tx_empty <= 1'b1;
        end
    end

    // Continuous-receive re-arm request, raised by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rearm <= 1'b0;
        else if (start) rearm <= 1'b0;
        else if (rd_rx && cfg_cont_rx && cfg_rx_en) rearm <= 1'b1;
    end

    // Receive holding register, full flag, overrun and receive pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb        <= '0;
            rx_full   <= 1'b0;
            overrun   <= 1'b0;
            frame_ovr <= 1'b0;
            rx_irq    <= 1'b0;
        end else begin
            rx_irq <= 1'b0;
            if (start) frame_ovr <= 1'b0;
            if (rd_rx) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
            if (seventh && cfg_rx_en && rx_full) begin
                overrun   <= 1'b1;
                frame_ovr <= 1'b1;
            end
            if (done && cfg_rx_en && !frame_ovr) begin
                rb      <= rx_next;
                rx_full <= 1'b1;
                rx_irq  <= 1'b1;
            end
        end
    end

    // Transmit pulse from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) tx_irq <= 1'b0;
        else        tx_irq <= (start && from_buf && !cfg_tx_irq_sel) ||
                              (done && cfg_tx_irq_sel);
    end
endmodule

// File: rtl/csio_channel_chk.sv
// Property checker for csio_channel, attached with bind below.
module csio_channel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_tx,
    input logic       rd_rx,
    input logic       busy,
    input logic       tx_empty,
    input logic       rx_full,
    input logic       overrun,
    input logic       tx_irq,
    input logic       rx_irq,
    input logic       cfg_tx_irq_sel,
    input logic       cfg_ext_clk,
    input logic       cfg_pol,
    input logic [1:0] cfg_flow,
    input logic       sclk_out,
    input logic       rts_n
);
    assert_rx_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    assert_rx_full_on_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_full);
    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_ext_clk) |-> (sclk_out == !cfg_pol));
    assert_empty_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_empty) |-> $rose(busy));
    assert_fill_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_tx));
    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !rd_rx) |=> overrun);
    assert_tx_pulse_move_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !$past(cfg_tx_irq_sel)) |-> $rose(busy));
    assert_tx_pulse_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && $past(cfg_tx_irq_sel)) |-> $fell(busy));
    assert_rts_after_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && cfg_flow == 2'b10) |-> rts_n);
    assert_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rx |=> (!rx_full || rx_irq));
endmodule

bind csio_channel csio_channel_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_tx          (wr_tx),
    .rd_rx          (rd_rx),
    .busy           (busy),
    .tx_empty       (tx_empty),
    .rx_full        (rx_full),
    .overrun        (overrun),
    .tx_irq         (tx_irq),
    .rx_irq         (rx_irq),
    .cfg_tx_irq_sel (cfg_tx_irq_sel),
    .cfg_ext_clk    (cfg_ext_clk),
    .cfg_pol        (cfg_pol),
    .cfg_flow       (cfg_flow),
    .sclk_out       (sclk_out),
    .rts_n          (rts_n)
);

// File: tb/csio_channel_tb_top.sv
// Scoreboard bench: send() queues expected wire bytes, a pin monitor
// rebuilds each frame at the sampling edges and compares.
module csio_channel_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, wr_tx, rd_rx;
    logic [7:0] wr_data;
    logic [7:0] rx_data;
    logic       cfg_tx_en, cfg_rx_en, cfg_ext_clk, cfg_pol, cfg_msb_first, cfg_invert;
    logic [1:0] cfg_flow;
    logic       cfg_tx_irq_sel, cfg_cont_rx;
    logic [7:0] cfg_div;
    logic       tx_empty, rx_full, overrun, tx_irq, rx_irq;
    logic       sclk_out, sclk_oe, txd, rts_n, cts_n;
    logic       ext_drv, loop_en, rxd_drv;
    logic       sclk_line, rxd;

    assign sclk_line = sclk_oe ? sclk_out : ext_drv;
    assign rxd       = loop_en ? txd : rxd_drv;

    csio_channel dut_i (
        .clk(clk), .rst_n(rst_n), .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx),
        .rx_data(rx_data), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_ext_clk(cfg_ext_clk), .cfg_pol(cfg_pol), .cfg_msb_first(cfg_msb_first),
        .cfg_invert(cfg_invert), .cfg_flow(cfg_flow), .cfg_tx_irq_sel(cfg_tx_irq_sel),
        .cfg_cont_rx(cfg_cont_rx), .cfg_div(cfg_div), .tx_empty(tx_empty),
        .rx_full(rx_full), .overrun(overrun), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .sclk_in(sclk_line), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd(txd),
        .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n)
    );

    int          errors = 0;
    int          checks = 0;
    int unsigned cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Scoreboard state.
    logic [7:0]  exp_q[$];
    int          exp_period = 0;
    string       mon_tag = "R1";
    int          bit_idx = 0;
    logic [7:0]  mon_byte = '0;
    int unsigned last_edge = 0;
    logic        prev_line = 1'b1;
    logic        prev_pol = 1'b0;
    int          rx_irq_cnt = 0, tx_irq_cnt = 0;
    int unsigned rx_irq_cyc = 0, tx_irq_cyc = 0;

    // Monitor: collect a bit at each sampling edge seen on the clock line.
    always @(negedge clk) begin
        if (rst_n && sclk_line !== prev_line && cfg_pol == prev_pol && sclk_line == ~cfg_pol) begin
            if (bit_idx > 0 && exp_period > 0)
                chk("R2", "transfer clock period", int'(cyc - last_edge), exp_period);
            last_edge = cyc;
            mon_byte[cfg_msb_first ? 7 - bit_idx : bit_idx] = txd ^ cfg_invert;
            bit_idx++;
            if (bit_idx == 8) begin
                bit_idx = 0;
                if (exp_q.size() == 0) chk(mon_tag, "unexpected frame", int'(mon_byte), -1);
                else chk(mon_tag, "wire byte", int'(mon_byte), int'(exp_q.pop_front()));
            end
        end
        prev_line = sclk_line;
        prev_pol  = cfg_pol;
    end

    // Stamp the interrupt pulses.
    always @(negedge clk) begin
        if (rst_n && rx_irq) begin rx_irq_cnt++; rx_irq_cyc = cyc; end
        if (rst_n && tx_irq) begin tx_irq_cnt++; tx_irq_cyc = cyc; end
    end

    task automatic write_tx(input logic [7:0] d);
        @(negedge clk); wr_tx = 1'b1; wr_data = d;
        @(negedge clk); wr_tx = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        exp_q.push_back(d);
        write_tx(d);
    endtask

    task automatic read_rx();
        @(negedge clk); rd_rx = 1'b1;
        @(negedge clk); rd_rx = 1'b0;
    endtask

    task automatic wait_q();
        int t = 0;
        while (exp_q.size() != 0 && t < 5000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic ext_frame();
        for (int i = 0; i < 8; i++) begin
            repeat (5) @(negedge clk); ext_drv = cfg_pol;
            repeat (5) @(negedge clk); ext_drv = ~cfg_pol;
        end
        repeat (6) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=150000 cycles expected=done earlier");
        summary();
        $finish;
    end

    initial begin
        int n0;
        rst_n = 1'b0; wr_tx = 1'b0; rd_rx = 1'b0; wr_data = '0;
        cfg_tx_en = 1'b0; cfg_rx_en = 1'b1; cfg_ext_clk = 1'b0; cfg_pol = 1'b0;
        cfg_msb_first = 1'b0; cfg_invert = 1'b0; cfg_flow = 2'b00;
        cfg_tx_irq_sel = 1'b0; cfg_cont_rx = 1'b0; cfg_div = 8'd0;
        cts_n = 1'b1; ext_drv = 1'b1; loop_en = 1'b1; rxd_drv = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state.
        chk("R5", "reset tx_empty", tx_empty, 1);
        chk("R1", "reset rx_full", rx_full, 0);
        chk("R6", "reset overrun", overrun, 0);
        chk("R3", "idle level pol0", sclk_out, 1);
        chk("R2", "internal drive enable", sclk_oe, 1);

        // R5: transmit disabled holds the byte.
        write_tx(8'h5A);
        repeat (60) @(negedge clk);
        chk("R5", "no start while disabled", tx_empty, 0);
        chk("R5", "no frame while disabled", rx_irq_cnt, 0);
        exp_q.push_back(8'h5A); exp_period = 2; mon_tag = "R1";
        cfg_tx_en = 1'b1;
        wait_q();
        chk("R1", "loopback byte", rx_data, 8'h5A);
        chk("R1", "rx_full after frame", rx_full, 1);
        chk("R1", "single rx pulse", rx_irq_cnt, 1);
        chk("R5", "buffer emptied", tx_empty, 1);
        read_rx();
        chk("R12", "read clears full", rx_full, 0);

        // R2/R4: divider 3, MSB first.
        cfg_div = 8'd3; exp_period = 8; cfg_msb_first = 1'b1; mon_tag = "R4";
        send(8'h1E); wait_q();
        chk("R4", "msb-first loopback", rx_data, 8'h1E);
        read_rx();

        // R3: polarity 1 idles low, edges swapped.
        cfg_msb_first = 1'b0; cfg_pol = 1'b1; cfg_div = 8'd1; exp_period = 4; mon_tag = "R3";
        @(negedge clk);
        chk("R3", "idle level pol1", sclk_out, 0);
        send(8'h96); wait_q();
        chk("R3", "pol1 loopback", rx_data, 8'h96);
        read_rx();

        // R9: inversion on both directions.
        cfg_pol = 1'b0; cfg_invert = 1'b1; mon_tag = "R9";
        send(8'h0F); wait_q();
        chk("R9", "inverted loopback", rx_data, 8'h0F);
        read_rx();
        cfg_invert = 1'b0;

        // R5: clear-to-send gating.
        cfg_flow = 2'b01; cts_n = 1'b1; mon_tag = "R5";
        send(8'h77);
        repeat (40) @(negedge clk);
        chk("R5", "held by cts", tx_empty, 0);
        chk("R5", "no bits while cts high", exp_q.size(), 1);
        cts_n = 1'b0; wait_q();
        chk("R5", "sent after cts", rx_data, 8'h77);
        read_rx();
        cfg_flow = 2'b00; cts_n = 1'b1;

        // R10: request-to-send.
        cfg_flow = 2'b10; @(negedge clk);
        chk("R10", "rts ready", rts_n, 0);
        mon_tag = "R10";
        send(8'h33); wait_q();
        chk("R10", "rts with full buffer", rts_n, 1);
        read_rx();
        chk("R10", "rts after read", rts_n, 0);
        cfg_rx_en = 1'b0; @(negedge clk);
        chk("R10", "rts rx disabled", rts_n, 1);
        cfg_rx_en = 1'b1; cfg_flow = 2'b00; @(negedge clk);
        chk("R10", "rts flow off", rts_n, 0);

        // R7: transmit pulse source.
        cfg_tx_irq_sel = 1'b0; mon_tag = "R7";
        n0 = tx_irq_cnt;
        send(8'h44); wait_q();
        chk("R7", "move pulse count", tx_irq_cnt - n0, 1);
        chk("R7", "move pulse lead", int'(rx_irq_cyc - tx_irq_cyc), 32);
        read_rx();
        cfg_tx_irq_sel = 1'b1;
        send(8'h55); wait_q();
        chk("R7", "end pulse lead", int'(rx_irq_cyc - tx_irq_cyc), 0);
        read_rx();
        cfg_tx_irq_sel = 1'b0;

        // R6: overrun.
        mon_tag = "R6";
        send(8'h11); wait_q();
        n0 = rx_irq_cnt;
        send(8'h22); wait_q();
        chk("R6", "overrun set", overrun, 1);
        chk("R6", "old byte kept", rx_data, 8'h11);
        chk("R6", "no rx pulse", rx_irq_cnt - n0, 0);
        read_rx();
        chk("R12", "read clears overrun", overrun, 0);
        chk("R12", "read clears full", rx_full, 0);
        send(8'h66); wait_q();
        chk("R6", "recovered", rx_data, 8'h66);
        read_rx();

        // R8: continuous receive re-arm.
        cfg_cont_rx = 1'b1; mon_tag = "R8";
        send(8'h3A); wait_q();
        n0 = rx_irq_cnt;
        exp_q.push_back(8'h3A);
        read_rx(); wait_q();
        chk("R8", "re-armed frame", rx_irq_cnt - n0, 1);
        chk("R8", "no write needed", tx_empty, 1);
        chk("R8", "re-armed byte", rx_data, 8'h3A);
        cfg_cont_rx = 1'b0;
        n0 = rx_irq_cnt;
        read_rx();
        repeat (60) @(negedge clk);
        chk("R8", "no re-arm when off", rx_irq_cnt - n0, 0);

        // R11: external clock.
        ext_drv = 1'b1; cfg_ext_clk = 1'b1; exp_period = 0; mon_tag = "R11";
        @(negedge clk);
        chk("R11", "pin released", sclk_oe, 0);
        send(8'hB4);
        repeat (30) @(negedge clk);
        chk("R11", "waits for edges", exp_q.size(), 1);
        ext_frame();
        chk("R11", "external frame sent", exp_q.size(), 0);
        chk("R11", "external loopback", rx_data, 8'hB4);
        read_rx();
        cfg_ext_clk = 1'b0;
        repeat (4) @(negedge clk);

        summary();
        $finish;
    end
endmodule